// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the general-purpose registers of a small 16-bit processor. Register numbers 0 to 7 are replicated across a parameterised number of banks, 256 by default. Register numbers 8 to 12 form one set that every bank sees. The active bank comes from the high byte of the processor status word, which is an input here. Software can therefore switch the whole low register set with ordinary arithmetic on the status word: adding 0x0100 moves up one bank, and masking with 0x00FF returns to bank 0.

There are two combinational read ports and one write port, each addressed by a 4-bit register number. Numbers 13 to 15 name the stack pointer, the status word and the program counter. The processor keeps those elsewhere, so this file neither stores them nor answers for them.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every stored register in every bank and in the shared set reads 0x0000.
- R2: The bank index is the low log2(NUM_BANKS) bits of status bits 15:8. Status bits 7:0 have no effect on any read or write.
- R3: Register numbers 0 to 7 (register number bit 3 = 0) are banked. A write lands only in the bank selected at the write edge, and the same register in every other bank keeps its value.
- R4: Register numbers 8 to 12 are shared. A value written under one bank reads back unchanged under any other bank.
- R5: A write addressed to register numbers 13, 14 or 15 changes no stored register. Reads of those numbers return 0x0000.
- R6: A write happens on the rising clock edge when the write enable is high, using the register number, data and bank present at that edge. When the write enable is low, an edge changes nothing.
- R7: Reads are combinational. A read of the register being written in the same cycle returns the old value until the clock edge and the new value after it.
- R8: A change of the status high byte changes which bank is read at once, with no clock edge needed. A walk of 0x0100 steps through the banks returns each bank's own contents.
- R9: The two read ports are independent. Each can address any register at the same time as the other.
- R10: With NUM_BANKS reduced to 16, only status bits 11:8 select the bank, so bank numbers that differ only in bits 15:12 reach the same storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| status_i | input | 16 | Processor status word; the high byte selects the bank |
| raddr_a_i | input | 4 | Register number for read port A |
| rdata_a_o | output | 16 | Read port A data |
| raddr_b_i | input | 4 | Register number for read port B |
| rdata_b_o | output | 16 | Read port B data |
| we_i | input | 1 | Write enable |
| waddr_i | input | 4 | Register number to write |
| wdata_i | input | 16 | Write data |

## Verification
The bench fills R0 and R1 of all 256 banks with bank-specific values, then walks back up in 0x0100 steps. A file that dropped or mis-sliced a bank-index bit would alias two banks, and one would show the other's value. Writes to numbers 13 to 15 are aimed at a bank where R5 to R7 and R12 hold known values, so a decoder that ignored bit 3, or that let slot 5 to 7 fall into the shared set, would corrupt one of them. Other checks catch a file that sampled the write early or fed the write data through to the read port: a write under a bank different from the read bank, a status low byte changed between write and read, and a same-cycle read of the register being written. A second instance with 16 banks confirms the aliasing through the upper status bits.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

    localparam int REG_NUM_W   = 4;
    localparam int BANKED_CNT  = 8;
    localparam int SHARED_BASE = 8;
    localparam int SHARED_CNT  = 5;
    localparam int SLOT_W      = 3;
    localparam int NUM_RD      = 2;

    typedef enum logic [1:0] {
        TGT_NONE   = 2'd0,
        TGT_BANKED = 2'd1,
        TGT_SHARED = 2'd2
    } rf_target_e;

    typedef struct packed {
        rf_target_e          tgt;
        logic [SLOT_W-1:0]   slot;
    } rf_route_t;

    function automatic rf_route_t route_reg(input logic [REG_NUM_W-1:0] num);
        rf_route_t r;
        r.slot = num[SLOT_W-1:0];
        if (!num[REG_NUM_W-1]) begin
            r.tgt = TGT_BANKED;
        end else if (num[SLOT_W-1:0] < SLOT_W'(SHARED_CNT)) begin
            r.tgt = TGT_SHARED;
        end else begin
            r.tgt = TGT_NONE;
        end
        return r;
    endfunction

endpackage

// File: rtl/rf_write_ctl.sv
module rf_write_ctl
    import banked_regfile_pkg::*;
(
    input  logic                 we_i,
    input  logic [REG_NUM_W-1:0] waddr_i,
    output logic                 bank_wr_en_o,
    output logic                 shared_wr_en_o,
    output logic [SLOT_W-1:0]    wr_slot_o
);
    rf_route_t route;

    always_comb begin
        route          = route_reg(waddr_i);
        wr_slot_o      = route.slot;
        bank_wr_en_o   = we_i && (route.tgt == TGT_BANKED);
        shared_wr_en_o = we_i && (route.tgt == TGT_SHARED);
    end
endmodule

// File: rtl/rf_bank_array.sv
module rf_bank_array
    import banked_regfile_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 256,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [BANK_W-1:0]             bank,
    input  logic [SLOT_W-1:0]             wr_slot,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NUM_RD-1:0][SLOT_W-1:0] rd_slot,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);
    localparam int DEPTH = NUM_BANKS * BANKED_CNT;
    localparam int IDX_W = BANK_W + SLOT_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  wr_idx_d;

    always_comb wr_idx_d = {bank, wr_slot};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx_d] <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        logic [IDX_W-1:0] rd_idx_d;
        always_comb begin
            rd_idx_d   = {bank, rd_slot[p]};
            rd_data[p] = mem_q[rd_idx_d];
        end
    end
endmodule

// File: rtl/rf_shared_regs.sv
module rf_shared_regs
    import banked_regfile_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SLOT_W-1:0]             wr_slot,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NUM_RD-1:0][SLOT_W-1:0] rd_slot,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [SHARED_CNT-1:0][DATA_W-1:0] regs;
    } shared_state_t;

    shared_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < SHARED_CNT; i++) begin
            if (wr_en && (wr_slot == SLOT_W'(i))) begin
                st_d.regs[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            rd_data[p] = '0;
            for (int i = 0; i < SHARED_CNT; i++) begin
                if (rd_slot[p] == SLOT_W'(i)) begin
                    rd_data[p] = st_q.regs[i];
                end
            end
        end
    end
endmodule

// File: rtl/rf_read_sel.sv
module rf_read_sel
    import banked_regfile_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [REG_NUM_W-1:0] raddr,
    input  logic [DATA_W-1:0]    banked_val,
    input  logic [DATA_W-1:0]    shared_val,
    output logic [DATA_W-1:0]    rdata
);
    rf_route_t route;

    always_comb begin
        route = route_reg(raddr);
        unique case (route.tgt)
            TGT_BANKED: rdata = banked_val;
            TGT_SHARED: rdata = shared_val;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_regfile_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] status_i,
    input  logic [3:0]  raddr_a_i,
    output logic [15:0] rdata_a_o,
    input  logic [3:0]  raddr_b_i,
    output logic [15:0] rdata_b_o,
    input  logic        we_i,
    input  logic [3:0]  waddr_i,
    input  logic [15:0] wdata_i
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int BANK_LSB = 8;

    logic [BANK_W-1:0]             bank_sel;
    logic                          bank_wr_en;
    logic                          shared_wr_en;
    logic [SLOT_W-1:0]             wr_slot;
    logic [NUM_RD-1:0][REG_NUM_W-1:0] raddr;
    logic [NUM_RD-1:0][SLOT_W-1:0] rd_slot;
    logic [NUM_RD-1:0][DATA_W-1:0] bank_rd;
    logic [NUM_RD-1:0][DATA_W-1:0] shared_rd;
    logic [NUM_RD-1:0][DATA_W-1:0] rdata;

    always_comb begin
        bank_sel = status_i[BANK_LSB +: BANK_W];
        raddr[0] = raddr_a_i;
        raddr[1] = raddr_b_i;
        for (int p = 0; p < NUM_RD; p++) begin
            rd_slot[p] = raddr[p][SLOT_W-1:0];
        end
        rdata_a_o = rdata[0];
        rdata_b_o = rdata[1];
    end

    rf_write_ctl u_wctl (
        .we_i           (we_i),
        .waddr_i        (waddr_i),
        .bank_wr_en_o   (bank_wr_en),
        .shared_wr_en_o (shared_wr_en),
        .wr_slot_o      (wr_slot)
    );

    rf_bank_array #(
        .DATA_W    (DATA_W),
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr_en),
        .bank    (bank_sel),
        .wr_slot (wr_slot),
        .wdata   (wdata_i),
        .rd_slot (rd_slot),
        .rd_data (bank_rd)
    );

    rf_shared_regs #(
        .DATA_W (DATA_W)
    ) u_shared (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (shared_wr_en),
        .wr_slot (wr_slot),
        .wdata   (wdata_i),
        .rd_slot (rd_slot),
        .rd_data (shared_rd)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        rf_read_sel #(
            .DATA_W (DATA_W)
        ) u_sel (
            .raddr      (raddr[p]),
            .banked_val (bank_rd[p]),
            .shared_val (shared_rd[p]),
            .rdata      (rdata[p])
        );
    end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
    parameter int BANK_W = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] status_i,
    input logic [3:0]  raddr_a_i,
    input logic [15:0] rdata_a_o,
    input logic [3:0]  raddr_b_i,
    input logic [15:0] rdata_b_o,
    input logic        we_i,
    input logic [3:0]  waddr_i,
    input logic [15:0] wdata_i,
    input logic        bank_wr_en,
    input logic        shared_wr_en
);
    AST_RSVD_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (waddr_i > 4'd12) |-> !(bank_wr_en || shared_wr_en)); // R5

    AST_TARGET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_wr_en, shared_wr_en})); // R3

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_b_i > 4'd12) |-> (rdata_b_o == 16'h0000)); // R5

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we_i) && ($past(waddr_i) <= 4'd12)
         && (raddr_a_i == $past(waddr_i))
         && ($past(waddr_i[3])
             || (status_i[8 +: BANK_W] == $past(status_i[8 +: BANK_W]))))
        |-> (rdata_a_o == $past(wdata_i))); // R6

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(we_i) && $stable(raddr_a_i)
         && $stable(status_i[8 +: BANK_W]))
        |-> $stable(rdata_a_o)); // R7
endmodule

bind banked_regfile banked_regfile_chk #(.BANK_W(BANK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .status_i     (status_i),
    .raddr_a_i    (raddr_a_i),
    .rdata_a_o    (rdata_a_o),
    .raddr_b_i    (raddr_b_i),
    .rdata_b_o    (rdata_b_o),
    .we_i         (we_i),
    .waddr_i      (waddr_i),
    .wdata_i      (wdata_i),
    .bank_wr_en   (bank_wr_en),
    .shared_wr_en (shared_wr_en)
);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] status = 16'h0000;
    logic [3:0]  raddr_a = 4'd0;
    logic [3:0]  raddr_b = 4'd0;
    logic        we = 1'b0;
    logic [3:0]  waddr = 4'd0;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata_a, rdata_b, sm_rdata_a, sm_rdata_b;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk(clk), .rst_n(rst_n), .status_i(status),
        .raddr_a_i(raddr_a), .rdata_a_o(rdata_a),
        .raddr_b_i(raddr_b), .rdata_b_o(rdata_b),
        .we_i(we), .waddr_i(waddr), .wdata_i(wdata)
    );

    banked_regfile #(.NUM_BANKS(16)) i_banked_regfile_nb16 (
        .clk(clk), .rst_n(rst_n), .status_i(status),
        .raddr_a_i(raddr_a), .rdata_a_o(sm_rdata_a),
        .raddr_b_i(raddr_b), .rdata_b_o(sm_rdata_b),
        .we_i(we), .waddr_i(waddr), .wdata_i(wdata)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] sr, input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        status = sr; waddr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] sr, input logic [3:0] a, input logic [3:0] b);
        @(negedge clk);
        status = sr; raddr_a = a; raddr_b = b;
        #1;
    endtask

    function automatic logic [15:0] r0_val(input int b);
        return 16'hA000 ^ 16'(b);
    endfunction
    function automatic logic [15:0] r1_val(input int b);
        return 16'h5000 + 16'(b * 3);
    endfunction

    task automatic t_reset;
        rd(16'h0000, 4'd0, 4'd7);
        chk("R1 bank0", rdata_a, 16'h0); chk("R1 bank0 r7", rdata_b, 16'h0);
        rd(16'hFF00, 4'd3, 4'd8);
        chk("R1 bank255", rdata_a, 16'h0); chk("R1 shared r8", rdata_b, 16'h0);
        rd(16'h8000, 4'd12, 4'd1);
        chk("R1 shared r12", rdata_a, 16'h0); chk("R1 bank128 r1", rdata_b, 16'h0);
    endtask

    task automatic t_walk;
        logic [15:0] sr;
        sr = 16'h003C | 16'hFF00;
        for (int b = 255; b >= 0; b--) begin
            wr(sr, 4'd0, r0_val(b));
            wr(sr, 4'd1, r1_val(b));
            sr = sr - 16'h0100;
        end
        sr = sr & 16'h00FF;
        for (int b = 0; b < 256; b++) begin
            rd(sr, 4'd0, 4'd1);
            chk("R3 R8 walk r0", rdata_a, r0_val(b));
            chk("R3 R8 walk r1", rdata_b, r1_val(b));
            sr = sr + 16'h0100;
        end
    endtask

    task automatic t_isolation;
        wr(16'h0700, 4'd5, 16'h5A5A);
        rd(16'h0600, 4'd5, 4'd5); chk("R3 bank6 r5", rdata_a, 16'h0);
        rd(16'h0800, 4'd5, 4'd0); chk("R3 bank8 r5", rdata_a, 16'h0);
        chk("R3 bank8 r0", rdata_b, r0_val(8));
        rd(16'h0700, 4'd5, 4'd0); chk("R3 bank7 r5", rdata_a, 16'h5A5A);
    endtask

    task automatic t_shared;
        wr(16'h4200, 4'd9, 16'hBEEF);
        wr(16'hFF00, 4'd12, 16'hC0DE);
        wr(16'h0100, 4'd8, 16'h0808);
        rd(16'h0000, 4'd9, 4'd12);
        chk("R4 r9 bank0", rdata_a, 16'hBEEF); chk("R4 r12 bank0", rdata_b, 16'hC0DE);
        rd(16'hFF00, 4'd8, 4'd9);
        chk("R4 r8 bank255", rdata_a, 16'h0808); chk("R4 r9 bank255", rdata_b, 16'hBEEF);
    endtask

    task automatic t_reserved;
        wr(16'h0900, 4'd5, 16'h0505);
        wr(16'h0900, 4'd6, 16'h0606);
        wr(16'h0900, 4'd7, 16'h0707);
        wr(16'h0900, 4'd12, 16'h0C0C);
        wr(16'h0900, 4'd13, 16'hFFFF);
        wr(16'h0900, 4'd14, 16'hEEEE);
        wr(16'h0900, 4'd15, 16'hDDDD);
        rd(16'h0900, 4'd13, 4'd14);
        chk("R5 read r13", rdata_a, 16'h0); chk("R5 read r14", rdata_b, 16'h0);
        rd(16'h0900, 4'd15, 4'd5);
        chk("R5 read r15", rdata_a, 16'h0); chk("R5 r5 kept", rdata_b, 16'h0505);
        rd(16'h0900, 4'd6, 4'd7);
        chk("R5 r6 kept", rdata_a, 16'h0606); chk("R5 r7 kept", rdata_b, 16'h0707);
        rd(16'h0900, 4'd12, 4'd9);
        chk("R5 r12 kept", rdata_a, 16'h0C0C); chk("R5 r9 kept", rdata_b, 16'hBEEF);
    endtask

    task automatic t_status_low;
        wr(16'h0A00, 4'd2, 16'h2A2A);
        rd(16'h0AFF, 4'd2, 4'd2); chk("R2 low ff", rdata_a, 16'h2A2A);
        rd(16'h0A55, 4'd2, 4'd2); chk("R2 low 55", rdata_b, 16'h2A2A);
        wr(16'h0BC3, 4'd2, 16'h2B2B);
        rd(16'h0B00, 4'd2, 4'd2); chk("R2 write low c3", rdata_a, 16'h2B2B);
    endtask

    task automatic t_we_low;
        @(negedge clk);
        status = 16'h0500; waddr = 4'd4; wdata = 16'hDEAD; we = 1'b0;
        @(negedge clk); @(negedge clk);
        rd(16'h0500, 4'd4, 4'd4); chk("R6 we low", rdata_a, 16'h0);
    endtask

    task automatic t_same_cycle;
        wr(16'h2000, 4'd3, 16'h1111);
        @(negedge clk);
        status = 16'h2000; raddr_a = 4'd3; waddr = 4'd3; wdata = 16'h2222; we = 1'b1;
        #1;
        chk("R7 old before edge", rdata_a, 16'h1111);
        @(posedge clk); #1;
        chk("R7 new after edge", rdata_a, 16'h2222);
        @(negedge clk); we = 1'b0;
    endtask

    task automatic t_bank_switch;
        rd(16'h0300, 4'd0, 4'd1);
        chk("R8 bank3", rdata_a, r0_val(3));
        status = 16'h0400; #1;
        chk("R8 immediate bank4", rdata_a, r0_val(4));
        status = 16'h0400 - 16'h0100 - 16'h0100; #1;
        chk("R8 immediate bank2", rdata_b, r1_val(2));
    endtask

    task automatic t_ports;
        rd(16'h9000, 4'd0, 4'd9);
        chk("R9 port a", rdata_a, r0_val(16'h90));
        chk("R9 port b", rdata_b, 16'hBEEF);
        rd(16'h9000, 4'd9, 4'd1);
        chk("R9 swap a", rdata_a, 16'hBEEF);
        chk("R9 swap b", rdata_b, r1_val(16'h90));
    endtask

    task automatic t_small;
        wr(16'h0300, 4'd6, 16'h0363);
        rd(16'h1300, 4'd6, 4'd6);
        chk("R10 alias 13", sm_rdata_a, 16'h0363);
        rd(16'hF300, 4'd6, 4'd6);
        chk("R10 alias f3", sm_rdata_b, 16'h0363);
        rd(16'h0400, 4'd6, 4'd6);
        chk("R10 other bank", sm_rdata_a, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_walk();
        t_isolation();
        t_shared();
        t_reserved();
        t_status_low();
        t_we_low();
        t_same_cycle();
        t_bank_switch();
        t_ports();
        t_small();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
        $finish;
    end
endmodule